// File: doc/BRIEF.md
# Address and Data Pin Fault Tester for a Byte-Wide Memory

This block hunts for broken address and data connections between a controller and a byte-wide parallel memory that has been loaded beforehand with a signature image. The image is defined by a combinational generator, which gives the expected byte for any address. The two extreme addresses hold complementary bytes, 0xFF at the bottom and 0x00 at the top. The addresses one bit away from either extreme each hold a code that identifies the single address bit that differs. All remaining addresses hold one of six well-separated filler bytes, chosen by the number of ones in the address.

After a start pulse the sequencer reads the bottom and top addresses in turn for as long as it runs. Each read therefore swings every address line and every data line. If an address pin fails, the read lands on a neighbour and returns that neighbour's pin code. If a data pin fails, the returned byte has a flipped bit. Either way the miss is pushed into a small log holding the address, the expected byte and the returned byte, so that the failing pin can be worked out later. An optional first phase reads the whole address space once in ascending order and checks every byte against the generator before the alternating phase begins.

Top module: `bus_probe_tester`

## Requirements
- R1: The expected byte at address 0 is 0xFF, and at the all-ones address (0x3FFFFF for the 22-bit default) it is 0x00.
- R2: An address with only bit i set, or with only bit i cleared, expects pin code i. The codes for i = 0..21 are 07,0B,0D,0E,16,1A,1C,1F,25,29,2C,2F,34,38,3D,3E,43,49,4A,4F,52,58.
- R3: Every other address expects the filler byte chosen by (number of ones in the address) mod 6, taken from the list 33,55,66,99,AA,CC with index 0 first.
- R4: In the run phase, completed reads alternate between address 0 and the all-ones address, starting at 0. `pass_cnt` rises by one each time a read of the all-ones address completes.
- R5: `mem_req` stays high with `mem_addr` unchanged until a cycle in which `mem_valid` is high. That cycle completes the read, and `mem_req` is low in the following cycle.
- R6: A completed read whose byte differs from the expected byte is queued in the log with its address, expected byte and returned byte. The oldest entry appears on the log outputs while `log_valid` is high, and `log_pop` removes it.
- R7: A miss that finds the log full is dropped and sets the sticky `log_overflow`. `mismatch_cnt` counts every miss, saturating at its maximum, and never decreases except when cleared by a start.
- R8: A start pulse clears the log, the overflow flag and both counters, and begins a new run. When `fill_en` is high together with the start pulse, the run begins with the fill-verify phase.
- R9: The fill-verify phase reads every address exactly once in ascending order, checks each byte as in R6, and then moves on to the alternating phase.
- R10: A stop pulse makes the block idle in the next cycle, with `mem_req` low and `busy` low. The log and the counters keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a new run (clears log and counters) |
| stop | input | 1 | End the run |
| fill_en | input | 1 | Sampled with start: run a full-space check first |
| mem_req | output | 1 | Read request, held until answered |
| mem_addr | output | AW | Read address |
| mem_valid | input | 1 | Read data present this cycle |
| mem_rdata | input | 8 | Returned byte |
| busy | output | 1 | A run is in progress |
| pass_cnt | output | CNT_W | Completed reads of the top address in this run |
| mismatch_cnt | output | CNT_W | Misses seen in this run, saturating |
| log_overflow | output | 1 | Sticky: a miss was dropped because the log was full |
| log_valid | output | 1 | Log holds at least one entry |
| log_addr | output | AW | Address of the oldest entry |
| log_exp | output | 8 | Expected byte of the oldest entry |
| log_act | output | 8 | Returned byte of the oldest entry |
| log_pop | input | 1 | Remove the oldest entry |

## Verification
The assertions check the protocol-level behaviour on every cycle: the request is held steady until it is answered, run-phase requests target only the two extreme addresses, a stop leaves the block idle, the overflow flag is sticky, the miss counter never falls, and the pass counter moves by at most one. The generator's byte values can only be shown by the bench's scenarios. These scenarios inject single address-bit flips and data-bit flips at either extreme and check the exact logged address, expected byte and returned byte. They also cover log overflow, clearing on start, and the ascending order and per-address checks of the fill phase on a small address space.

// File: rtl/bus_probe_tester.sv
module bus_probe_tester #(
  parameter int AW        = 22,
  parameter int LOG_DEPTH = 4,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             fill_en,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_valid,
  input  logic [7:0]       mem_rdata,
  output logic             busy,
  output logic [CNT_W-1:0] pass_cnt,
  output logic [CNT_W-1:0] mismatch_cnt,
  output logic             log_overflow,
  output logic             log_valid,
  output logic [AW-1:0]    log_addr,
  output logic [7:0]       log_exp,
  output logic [7:0]       log_act,
  input  logic             log_pop
);
  localparam int LPW = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1;
  localparam int CW  = LPW + 1;
  localparam logic [CW-1:0] FULL = CW'(LOG_DEPTH);
  localparam logic [AW-1:0] TOP  = {AW{1'b1}};
  localparam logic [1:0] PH_IDLE = 2'd0, PH_FILL = 2'd1, PH_RUN = 2'd2;

  function automatic logic [7:0] pin_code(input int i);
    case (i)
      0: pin_code = 8'h07;  1: pin_code = 8'h0B;  2: pin_code = 8'h0D;  3: pin_code = 8'h0E;
      4: pin_code = 8'h16;  5: pin_code = 8'h1A;  6: pin_code = 8'h1C;  7: pin_code = 8'h1F;
      8: pin_code = 8'h25;  9: pin_code = 8'h29; 10: pin_code = 8'h2C; 11: pin_code = 8'h2F;
     12: pin_code = 8'h34; 13: pin_code = 8'h38; 14: pin_code = 8'h3D; 15: pin_code = 8'h3E;
     16: pin_code = 8'h43; 17: pin_code = 8'h49; 18: pin_code = 8'h4A; 19: pin_code = 8'h4F;
     20: pin_code = 8'h52; default: pin_code = 8'h58;
    endcase
  endfunction

  function automatic logic [7:0] expect_byte(input logic [AW-1:0] a);
    int n;
    logic [7:0] r;
    n = 0;
    for (int i = 0; i < AW; i++) n += int'(a[i]);
    r = 8'h00;
    if (n == 0) r = 8'hFF;
    else if (n == AW) r = 8'h00;
    else if (n == 1) begin
      for (int i = 0; i < AW; i++) if (a[i]) r = pin_code(i);
    end else if (n == AW - 1) begin
      for (int i = 0; i < AW; i++) if (!a[i]) r = pin_code(i);
    end else begin
      case (n % 6)
        0: r = 8'h33; 1: r = 8'h55; 2: r = 8'h66;
        3: r = 8'h99; 4: r = 8'hAA; default: r = 8'hCC;
      endcase
    end
    return r;
  endfunction

  logic [1:0]    phase;
  logic          req_q;
  logic [AW-1:0] addr_q;
  logic [LPW-1:0] wp, rp;
  logic [CW-1:0]  cnt;
  logic [AW+15:0] log_mem [LOG_DEPTH];

  wire [7:0] exp_w = expect_byte(addr_q);
  wire done  = req_q && mem_valid && (phase != PH_IDLE) && !start && !stop;
  wire miss  = done && (mem_rdata != exp_w);
  wire full  = (cnt == FULL);
  wire push  = miss && !full;
  wire pop   = log_pop && (cnt != '0) && !start;

  assign mem_req   = req_q;
  assign mem_addr  = addr_q;
  assign busy      = (phase != PH_IDLE);
  assign log_valid = (cnt != '0);
  assign {log_addr, log_exp, log_act} = log_mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; req_q <= 1'b0; addr_q <= '0;
      pass_cnt <= '0; mismatch_cnt <= '0; log_overflow <= 1'b0;
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (start) begin
      phase <= fill_en ? PH_FILL : PH_RUN; req_q <= 1'b1; addr_q <= '0;
      pass_cnt <= '0; mismatch_cnt <= '0; log_overflow <= 1'b0;
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (stop) begin
        phase <= PH_IDLE; req_q <= 1'b0;
      end else if (done) begin
        req_q <= 1'b0;
        if (phase == PH_FILL) begin
          if (addr_q == TOP) begin phase <= PH_RUN; addr_q <= '0; end
          else addr_q <= addr_q + 1'b1;
        end else begin
          addr_q <= (addr_q == '0) ? TOP : '0;
          if (addr_q == TOP) pass_cnt <= pass_cnt + 1'b1;
        end
      end else if (phase != PH_IDLE && !req_q) begin
        req_q <= 1'b1;
      end
      if (miss && mismatch_cnt != '1) mismatch_cnt <= mismatch_cnt + 1'b1;
      if (miss && full) log_overflow <= 1'b1;
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (push && !pop) cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (push && !start) log_mem[wp] <= {addr_q, exp_w, mem_rdata};
endmodule

module bus_probe_tester_chk #(
  parameter int AW    = 22,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic             mem_req,
  input logic             mem_valid,
  input logic [AW-1:0]    mem_addr,
  input logic             busy,
  input logic [1:0]       phase,
  input logic             log_overflow,
  input logic [CNT_W-1:0] mismatch_cnt,
  input logic [CNT_W-1:0] pass_cnt
);
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid && !start && !stop |=> mem_req && $stable(mem_addr));
  a_r4_probe_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && phase == 2'd2 |-> (mem_addr == '0 || mem_addr == {AW{1'b1}}));
  a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !start |=> !mem_req && !busy);
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    log_overflow && !start |=> log_overflow);
  a_r7_count_mono: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> mismatch_cnt >= $past(mismatch_cnt));
  a_r4_pass_step: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (pass_cnt == $past(pass_cnt) || pass_cnt == $past(pass_cnt) + 1'b1));
endmodule

bind bus_probe_tester bus_probe_tester_chk #(.AW(AW), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .mem_req(mem_req),
  .mem_valid(mem_valid), .mem_addr(mem_addr), .busy(busy), .phase(phase),
  .log_overflow(log_overflow), .mismatch_cnt(mismatch_cnt), .pass_cnt(pass_cnt));

// File: tb/bus_probe_tester_tb.sv
module bus_probe_tester_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 22;
  localparam int FW = 6;
  localparam int DEPTH = 4;
  localparam logic [AW-1:0] TOPA = {AW{1'b1}};

  // mask(22) xor(8) mode(2: 0 bottom, 1 top, 2 both, 3 none) exp_addr(22) exp_byte(8) act_byte(8)
  localparam int NV = 7;
  localparam logic [69:0] VEC [NV] = '{
    {22'h000001, 8'h00, 2'd0, 22'h000000, 8'hFF, 8'h07},
    {22'h200000, 8'h00, 2'd0, 22'h000000, 8'hFF, 8'h58},
    {22'h000020, 8'h00, 2'd0, 22'h000000, 8'hFF, 8'h1A},
    {22'h000000, 8'h10, 2'd0, 22'h000000, 8'hFF, 8'hEF},
    {22'h000008, 8'h00, 2'd1, 22'h3FFFFF, 8'h00, 8'h0E},
    {22'h000000, 8'h01, 2'd1, 22'h3FFFFF, 8'h00, 8'h01},
    {22'h200000, 8'h00, 2'd1, 22'h3FFFFF, 8'h00, 8'h58}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop = 0, fill_en = 0, log_pop = 0;
  logic m_req, m_valid = 0, busy, ovf, lvalid;
  logic [AW-1:0] m_addr, laddr;
  logic [7:0] m_rdata = 0, lexp, lact;
  logic [15:0] pcnt, mcnt;
  logic f_start = 0, f_stop = 0, f_pop = 0;
  logic f_req, f_valid = 0, f_busy, f_ovf, f_lvalid;
  logic [FW-1:0] f_addr, f_laddr;
  logic [7:0] f_rdata = 0, f_lexp, f_lact;
  logic [15:0] f_pcnt, f_mcnt;

  logic [AW-1:0] fx_mask = 0;
  logic [7:0] fx_xor = 0;
  logic [1:0] fx_mode = 2'd3;
  int checks = 0, fails = 0;
  int comp_n = 0, top_n = 0, alt_err = 0, f_n = 0, f_err = 0;
  logic [AW-1:0] last_a = TOPA;

  always #(CLK_P/2) clk = ~clk;

  bus_probe_tester #(.AW(AW), .LOG_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .fill_en(fill_en),
    .mem_req(m_req), .mem_addr(m_addr), .mem_valid(m_valid), .mem_rdata(m_rdata),
    .busy(busy), .pass_cnt(pcnt), .mismatch_cnt(mcnt), .log_overflow(ovf),
    .log_valid(lvalid), .log_addr(laddr), .log_exp(lexp), .log_act(lact), .log_pop(log_pop));

  bus_probe_tester #(.AW(FW), .LOG_DEPTH(DEPTH)) dut_fill_i (
    .clk(clk), .rst_n(rst_n), .start(f_start), .stop(f_stop), .fill_en(1'b1),
    .mem_req(f_req), .mem_addr(f_addr), .mem_valid(f_valid), .mem_rdata(f_rdata),
    .busy(f_busy), .pass_cnt(f_pcnt), .mismatch_cnt(f_mcnt), .log_overflow(f_ovf),
    .log_valid(f_lvalid), .log_addr(f_laddr), .log_exp(f_lexp), .log_act(f_lact), .log_pop(f_pop));

  function automatic logic [7:0] ref_byte(input logic [21:0] a, input int w);
    logic [7:0] codes [22];
    logic [7:0] fill [6];
    int n, idx;
    codes = '{8'h07,8'h0B,8'h0D,8'h0E,8'h16,8'h1A,8'h1C,8'h1F,8'h25,8'h29,8'h2C,
              8'h2F,8'h34,8'h38,8'h3D,8'h3E,8'h43,8'h49,8'h4A,8'h4F,8'h52,8'h58};
    fill = '{8'h33,8'h55,8'h66,8'h99,8'hAA,8'hCC};
    n = 0; idx = 0;
    for (int i = 0; i < w; i++) n += int'(a[i]);
    if (n == 0) return 8'hFF;
    if (n == w) return 8'h00;
    if (n == 1) begin for (int i = 0; i < w; i++) if (a[i]) idx = i; return codes[idx]; end
    if (n == w - 1) begin for (int i = 0; i < w; i++) if (!a[i]) idx = i; return codes[idx]; end
    return fill[n % 6];
  endfunction

  always @(posedge clk) begin
    logic hit;
    logic [AW-1:0] ea;
    hit = (fx_mode == 2'd2) || (fx_mode == 2'd0 && m_addr == '0) || (fx_mode == 2'd1 && m_addr == TOPA);
    ea = hit ? (m_addr ^ fx_mask) : m_addr;
    m_valid <= m_req && !m_valid;
    m_rdata <= ref_byte(ea, AW) ^ (hit ? fx_xor : 8'h00);
    f_valid <= f_req && !f_valid;
    f_rdata <= ref_byte(22'(f_addr), FW) ^ (f_addr == 6'h15 ? 8'h01 : (f_addr == 6'h3E ? 8'h80 : 8'h00));
  end

  // monitor of completed reads, from the ports
  always @(posedge clk) begin
    if (start) begin comp_n <= 0; top_n <= 0; alt_err <= 0; last_a <= TOPA; end
    else if (busy && m_req && m_valid && !stop) begin
      comp_n <= comp_n + 1;
      if (m_addr == TOPA) top_n <= top_n + 1;
      if (m_addr == last_a || (m_addr != '0 && m_addr != TOPA)) alt_err <= alt_err + 1;
      last_a <= m_addr;
    end
    if (f_start) begin f_n <= 0; f_err <= 0; end
    else if (f_busy && f_req && f_valid && !f_stop) begin
      f_n <= f_n + 1;
      if (f_n < 64) begin if (int'(f_addr) != f_n) f_err <= f_err + 1; end
      else if (int'(f_addr) != (((f_n - 64) % 2 == 1) ? 63 : 0)) f_err <= f_err + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start(input bit f);
    fill_en = f; start = 1; cyc(1); start = 0; fill_en = 0;
  endtask

  task automatic pulse_stop();
    stop = 1; cyc(1); stop = 0;
  endtask

  task automatic drain(output int n);
    n = 0;
    while (lvalid && n < 20) begin log_pop = 1; cyc(1); log_pop = 0; n++; end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int np, w;
    logic [AW-1:0] v_mask, v_addr;
    logic [7:0] v_xor, v_exp, v_act;
    logic [1:0] v_mode;
    cyc(3);
    // R10 reset state
    chk(!m_req && !busy && !lvalid && !ovf && pcnt == 0 && mcnt == 0, "R10 reset idle",
        {m_req, busy, lvalid, ovf}, 0);
    rst_n = 1; cyc(2);

    // vector table: R1 R2 R3 R6 single pin faults at each probe
    for (int k = 0; k < NV; k++) begin
      {v_mask, v_xor, v_mode, v_addr, v_exp, v_act} = VEC[k];
      fx_mask = v_mask; fx_xor = v_xor; fx_mode = v_mode;
      cyc(3);
      pulse_start(0);
      w = 0;
      while (!lvalid && w < 100) begin cyc(1); w++; end
      chk(lvalid, "R6 miss logged", lvalid, 1);
      chk(laddr == v_addr, "R6 log address", laddr, v_addr);
      chk(lexp == v_exp, "R1/R2 expected byte", lexp, v_exp);
      chk(lact == v_act, "R2 returned pin code", lact, v_act);
      pulse_stop();
      drain(np);
      fx_mode = 2'd3; fx_mask = 0; fx_xor = 0;
    end

    // R4 clean alternation and pass count
    cyc(3);
    pulse_start(0);
    cyc(60);
    pulse_stop();
    chk(!m_req && !busy, "R10 idle after stop", {m_req, busy}, 0);
    chk(mcnt == 0 && !lvalid, "R4 clean run no miss", mcnt, 0);
    chk(alt_err == 0, "R4 alternation order", alt_err, 0);
    chk(int'(pcnt) == top_n && top_n >= 9, "R4 pass count", pcnt, top_n);
    chk(comp_n >= 18, "R5 reads completed", comp_n, 18);

    // R7 overflow: every read misses
    cyc(3);
    fx_mode = 2'd2; fx_xor = 8'hFF;
    pulse_start(0);
    cyc(40);
    pulse_stop();
    chk(ovf, "R7 overflow set", ovf, 1);
    chk(int'(mcnt) == comp_n && comp_n > DEPTH, "R7 miss count", mcnt, comp_n);
    chk(laddr == '0 && lexp == 8'hFF && lact == 8'h00, "R6 oldest entry first", {laddr, lexp, lact}, 32'hFF00);
    cyc(5);
    chk(ovf && int'(mcnt) == comp_n, "R10 state kept after stop", mcnt, comp_n);
    drain(np);
    chk(np == DEPTH, "R7 log holds depth entries", np, DEPTH);
    chk(ovf, "R7 overflow sticky after pops", ovf, 1);
    fx_mode = 2'd3; fx_xor = 0;

    // R8 start clears
    cyc(3);
    pulse_start(0);
    cyc(1);
    chk(!ovf && mcnt == 0 && pcnt == 0 && !lvalid, "R8 start clears", {ovf, lvalid}, 0);
    chk(busy, "R8 run begins", busy, 1);
    pulse_stop();

    // R9 fill-verify on small space
    cyc(3);
    f_start = 1; cyc(1); f_start = 0;
    cyc(64 * 3 + 40);
    f_stop = 1; cyc(1); f_stop = 0;
    chk(f_n > 64 && f_err == 0, "R9 fill order then alternation", f_err, 0);
    chk(f_mcnt == 2, "R9 fill miss count", f_mcnt, 2);
    chk(f_lvalid && f_laddr == 6'h15 && f_lexp == 8'h99 && f_lact == 8'h98, "R3 fill first entry",
        {f_laddr, f_lexp, f_lact}, {6'h15, 8'h99, 8'h98});
    f_pop = 1; cyc(1); f_pop = 0;
    chk(f_lvalid && f_laddr == 6'h3E && f_lexp == 8'h07 && f_lact == 8'h87, "R2 fill second entry",
        {f_laddr, f_lexp, f_lact}, {6'h3E, 8'h07, 8'h87});
    f_pop = 1; cyc(1); f_pop = 0;
    chk(!f_lvalid, "R6 log empty after pops", f_lvalid, 0);
    chk(f_pcnt > 0, "R9 run phase reached", f_pcnt, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule